// File: doc/BRIEF.md
# Express-Link Back-Pressure Suppression Filter

This block sits in every router that lies within two hops of an express-link router. When one of that router's express queues fills up, the router sends an unsafe notice back over the credit links, tagged with the index of the express-link router concerned. The filter then opens a suppression window of a fixed number of cycles for that index.

While the window is open, a head flit that is an express candidate aimed at that index loses its candidate flag. It then carries on by plain XY routing, and the filter marks it for re-injection through the local-port virtual channel. Each index keeps its own window, so a notice for one express router leaves traffic to the others alone. A cleared flag is never set again, and a flit that is not a candidate passes through untouched.

Every head flit passes through one register stage. A notice takes effect from the cycle after it arrives. A notice that arrives while the window is open restarts that window at its full length.

Top module: `sup_bp_filter`

## Requirements
- R1: After reset, `out_vld` and `out_reinject` are 0 and every suppression window is closed.
- R2: A head flit presented with `flit_vld`=1 appears on the outputs exactly one clock later with `out_vld`=1, and `out_dst` equals its `flit_dst`. A cycle with `flit_vld`=0 gives `out_vld`=0 one clock later.
- R3: After a cycle with `notice_vld`=1 and `notice_id`=k, the window for k is open during the next WIN_CYC cycles (default 4). A flit with `flit_cand`=1 and `flit_tgt`=k presented in those cycles leaves with `out_cand`=0 and `out_reinject`=1.
- R4: Some candidate flits to k leave with `out_cand`=1 and `out_reinject`=0. This holds for one presented in the same cycle as the notice (when no window was already open), and for one presented WIN_CYC+1 or more cycles after the last notice for k.
- R5: A notice for k that arrives while k's window is open restarts the window. It then stays open for WIN_CYC cycles counted from the new notice.
- R6: A notice for index k has no effect on candidate flits whose `flit_tgt` differs from k.
- R7: A flit with `flit_cand`=0 always leaves with `out_cand`=0 and `out_reinject`=0, even while a window is open.
- R8: `out_tgt` always equals the `flit_tgt` of the same flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notice_vld | input | 1 | Unsafe notice received this cycle |
| notice_id | input | TGT_W | Express-link router index that the notice refers to |
| flit_vld | input | 1 | Head flit present this cycle |
| flit_cand | input | 1 | Express-candidate flag of the head flit |
| flit_tgt | input | TGT_W | Express-link router index that the flit is steered to |
| flit_dst | input | DST_W | Final destination node of the flit |
| out_vld | output | 1 | Rewritten head flit valid |
| out_cand | output | 1 | Candidate flag after filtering |
| out_tgt | output | TGT_W | Express-link router index, unchanged |
| out_dst | output | DST_W | Destination node, unchanged |
| out_reinject | output | 1 | Flit was rejected and must be re-injected through the local-port virtual channel |

## Verification
Each flit result is due one clock after the flit is presented. A notice shapes the flits presented one to WIN_CYC cycles after it, but not the flit in its own cycle. The driver works out the result for each flit from a per-index model of the windows in the cycle it presents that flit, and pushes it into a queue. The monitor samples on the falling edge, half a cycle after the register stage loads. It pops one entry for every valid output, so each comparison lands in the cycle the result is due.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int SUP_NUM_XR_DEF  = 4;
    localparam int SUP_WIN_CYC_DEF = 4;
    localparam int SUP_DST_W_DEF   = 6;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sup_win_timer.sv
module sup_win_timer #(
    parameter int WIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic open_o
);
    localparam int CW = $clog2(WIN_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = CW'(WIN_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = (st_q.cnt != '0);

    // R3: a notice opens the window from the next cycle
    p_load_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> open_o);

    // R4: with no notice, the last open cycle is followed by a closed one
    p_expires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cnt == CW'(1)) |=> !open_o);

    // R5: the count never exceeds one full window
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(WIN_CYC));
endmodule

// File: rtl/sup_head_rewrite.sv
module sup_head_rewrite #(
    parameter int TGT_W = 2,
    parameter int DST_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flit_vld,
    input  logic             flit_cand,
    input  logic [TGT_W-1:0] flit_tgt,
    input  logic [DST_W-1:0] flit_dst,
    input  logic             suppress_i,
    output logic             out_vld,
    output logic             out_cand,
    output logic [TGT_W-1:0] out_tgt,
    output logic [DST_W-1:0] out_dst,
    output logic             out_reinject
);
    typedef struct packed {
        logic             vld;
        logic             cand;
        logic             rej;
        logic [TGT_W-1:0] tgt;
        logic [DST_W-1:0] dst;
    } hd_t;

    hd_t hd_d, hd_q;

    always_comb begin
        hd_d      = hd_q;
        hd_d.vld  = flit_vld;
        hd_d.cand = 1'b0;
        hd_d.rej  = 1'b0;
        if (flit_vld) begin
            hd_d.tgt  = flit_tgt;
            hd_d.dst  = flit_dst;
            hd_d.cand = flit_cand & ~suppress_i;
            hd_d.rej  = flit_cand & suppress_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign out_vld      = hd_q.vld;
    assign out_cand     = hd_q.cand;
    assign out_reinject = hd_q.rej;
    assign out_tgt      = hd_q.tgt;
    assign out_dst      = hd_q.dst;

    // R7: the candidate flag is never raised by this block
    p_never_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flit_vld && !flit_cand |=> !out_cand && !out_reinject);

    // R3: a rejected flit is valid and no longer a candidate
    p_reject_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_reinject |-> out_vld && !out_cand);

    // R2: valid follows the input one cycle later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_vld |=> !out_vld);
endmodule

// File: rtl/sup_bp_filter.sv
module sup_bp_filter
    import sup_pkg::*;
#(
    parameter int NUM_XR  = SUP_NUM_XR_DEF,
    parameter int WIN_CYC = SUP_WIN_CYC_DEF,
    parameter int DST_W   = SUP_DST_W_DEF,
    parameter int TGT_W   = idx_width(NUM_XR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             notice_vld,
    input  logic [TGT_W-1:0] notice_id,
    input  logic             flit_vld,
    input  logic             flit_cand,
    input  logic [TGT_W-1:0] flit_tgt,
    input  logic [DST_W-1:0] flit_dst,
    output logic             out_vld,
    output logic             out_cand,
    output logic [TGT_W-1:0] out_tgt,
    output logic [DST_W-1:0] out_dst,
    output logic             out_reinject
);
    logic [NUM_XR-1:0] load_vec;
    logic [NUM_XR-1:0] open_vec;
    logic              suppress;

    for (genvar k = 0; k < NUM_XR; k++) begin : g_win
        assign load_vec[k] = notice_vld && (notice_id == TGT_W'(k));
        sup_win_timer #(.WIN_CYC(WIN_CYC)) i_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_vec[k]),
            .open_o (open_vec[k])
        );
    end

    always_comb begin
        suppress = 1'b0;
        for (int k = 0; k < NUM_XR; k++) begin
            if (flit_tgt == TGT_W'(k)) suppress = open_vec[k];
        end
    end

    sup_head_rewrite #(.TGT_W(TGT_W), .DST_W(DST_W)) i_rw (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_vld     (flit_vld),
        .flit_cand    (flit_cand),
        .flit_tgt     (flit_tgt),
        .flit_dst     (flit_dst),
        .suppress_i   (suppress),
        .out_vld      (out_vld),
        .out_cand     (out_cand),
        .out_tgt      (out_tgt),
        .out_dst      (out_dst),
        .out_reinject (out_reinject)
    );

    // R6: a single notice opens at most one index's window
    p_isolation_r6: assert property (@(posedge clk) disable iff (!rst_n)
        notice_vld && ($countones(open_vec) == 0) |=> $onehot0(open_vec));

    // R8: the target index is carried through unchanged
    p_tgt_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flit_vld |=> out_tgt == $past(flit_tgt));
endmodule

// File: tb/test_sup_bp_filter.sv
module test_sup_bp_filter;
    localparam int NXR = 4;
    localparam int WIN = 4;
    localparam int TW  = 2;
    localparam int DW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          notice_vld = 1'b0;
    logic [TW-1:0] notice_id = '0;
    logic          flit_vld = 1'b0;
    logic          flit_cand = 1'b0;
    logic [TW-1:0] flit_tgt = '0;
    logic [DW-1:0] flit_dst = '0;
    logic          out_vld, out_cand, out_reinject;
    logic [TW-1:0] out_tgt;
    logic [DW-1:0] out_dst;

    always #4 clk = ~clk;

    sup_bp_filter #(.NUM_XR(NXR), .WIN_CYC(WIN), .DST_W(DW)) i_sup_bp_filter (
        .clk(clk), .rst_n(rst_n), .notice_vld(notice_vld), .notice_id(notice_id),
        .flit_vld(flit_vld), .flit_cand(flit_cand), .flit_tgt(flit_tgt),
        .flit_dst(flit_dst), .out_vld(out_vld), .out_cand(out_cand),
        .out_tgt(out_tgt), .out_dst(out_dst), .out_reinject(out_reinject));

    typedef struct {
        logic          cand;
        logic          rej;
        logic [TW-1:0] tgt;
        logic [DW-1:0] dst;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   win_left[NXR];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 1'b0;

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic step(input bit nv, input int nid, input bit fv, input bit c,
                        input int t, input int d, input string tag);
        exp_t e;
        notice_vld = nv;
        notice_id  = TW'(nid);
        flit_vld   = fv;
        flit_cand  = c;
        flit_tgt   = TW'(t);
        flit_dst   = DW'(d);
        if (fv) begin
            e.cand = c && (win_left[t] == 0);
            e.rej  = c && (win_left[t] != 0);
            e.tgt  = TW'(t);
            e.dst  = DW'(d);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        for (int k = 0; k < NXR; k++) if (win_left[k] > 0) win_left[k]--;
        if (nv) win_left[nid] = WIN;
        @(posedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        if (mon_on && out_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_vld: actual 1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_cand == e.cand && out_reinject == e.rej &&
                      out_tgt == e.tgt && out_dst == e.dst, e.tag,
                      $sformatf("cand/rej/tgt/dst actual %0b/%0b/%0d/%0d expected %0b/%0b/%0d/%0d",
                                out_cand, out_reinject, out_tgt, out_dst,
                                e.cand, e.rej, e.tgt, e.dst));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < NXR; k++) win_left[k] = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_vld == 1'b0 && out_reinject == 1'b0, "R1",
              $sformatf("vld/rej actual %0b/%0b expected 0/0", out_vld, out_reinject));
        @(posedge clk);
        #1;
        mon_on = 1'b1;
        // R1 windows closed after reset, R2 and R8 pass-through
        for (int t = 0; t < NXR; t++) step(0, 0, 1, 1, t, 10 + t, "R1");
        for (int t = 0; t < NXR; t++) step(0, 0, 1, 0, t, 20 + t, "R8");
        step(0, 0, 0, 0, 0, 0, "R2");
        // R4 flit in notice cycle kept, R3 next four suppressed, R4 fifth kept
        step(1, 1, 1, 1, 1, 30, "R4");
        for (int i = 0; i < WIN; i++) step(0, 0, 1, 1, 1, 31 + i, "R3");
        step(0, 0, 1, 1, 1, 40, "R4");
        // R6 isolation between indices
        step(1, 2, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 1, 0, 41, "R6");
        step(0, 0, 1, 1, 3, 42, "R6");
        step(0, 0, 1, 1, 2, 43, "R3");
        step(0, 0, 1, 1, 1, 44, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        // R5 reload mid-window
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 0, 50, "R5");
        step(1, 0, 1, 1, 0, 51, "R5");
        for (int i = 0; i < WIN + 2; i++) step(0, 0, 1, 1, 0, 52 + i, "R5");
        // R7 non-candidates during an open window
        step(1, 3, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 3, 60, "R7");
        step(0, 0, 1, 1, 3, 61, "R3");
        step(0, 0, 1, 0, 3, 62, "R7");
        // back-to-back notices on different indices, R6
        step(1, 1, 1, 1, 2, 63, "R6");
        step(1, 2, 1, 1, 1, 0, "R3");
        step(0, 0, 1, 1, 2, 1, "R3");
        step(0, 0, 1, 1, 0, 2, "R6");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        @(negedge clk);
        check(exp_q.size() == 0, "R2",
              $sformatf("pending actual %0d expected 0", exp_q.size()));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule